// File: doc/BRIEF.md
# Exception Entry Unit

This block computes everything a small core needs to enter an exception handler. An exception request lasts one cycle. It carries the exception code, the number of the coprocessor that caused the fault, a flag that marks a translation-miss refill, the PC of the faulting instruction and the PC that would have followed it. From this request and the current Status, Cause and exception-base register values, the unit produces four results. These are the handler address for the fetch redirect, the new exception PC, and the updated Cause and Status words. All four appear together on registered outputs one cycle after the request.

The unit detects that the faulting instruction sits in a branch delay slot when the next PC is not the instruction that follows it in sequence. In that case it backs the saved PC up to the branch. The handler address is a base plus an offset. The base is either the exception-base register or a fixed boot address, chosen by a Status bit. The offset is chosen from the kind of exception and from the register values as they stood before entry. Pipeline flushing, interrupt arbitration and the return path are handled elsewhere.

Top module: `exc_entry_unit`

## Requirements
- R1: `out_valid` is 1 in exactly the cycle after a cycle with `exc_req` = 1, and 0 otherwise. Without a request, `redirect_pc`, `epc_out`, `cause_out` and `status_out` hold their last values.
- R2: The faulting instruction counts as a delay-slot instruction when `next_pc` differs from `fault_pc` + 4.
- R3: `epc_out` is `fault_pc` − 4 for a delay-slot instruction, and `fault_pc` unchanged otherwise.
- R4: Cause bit 31 (branch-delay flag) in `cause_out` is 1 when the instruction was in a delay slot and 0 otherwise, whatever its value in `cause_in`.
- R5: The vector base is `ebase_in` when Status bit 22 (boot-vector select) is 0, and 32'hBFC00200 when it is 1.
- R6: For an interrupt (code 0), the offset is 0x200 when Cause bit 23 (special interrupt vector) is 1, and 0x180 when it is 0.
- R7: For a refill request (`exc_refill` = 1), the offset is 0x000 when Status bit 1 (exception level) was 0 before entry, and 0x180 when it was 1. Every other non-interrupt exception uses 0x180.
- R8: Cause bits 6:2 of `cause_out` take `exc_code` on every entry.
- R9: For code 11 (coprocessor unusable), Cause bits 29:28 take `exc_cop`. For any other code, those bits keep their `cause_in` value.
- R10: `status_out` equals `status_in` with bit 1 set. Cause bits not named in R4, R8 and R9 pass through from `cause_in` unchanged.
- R11: While `rst` is 1, all outputs are driven to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_code | input | 5 | Exception code |
| exc_cop | input | 2 | Offending coprocessor number |
| exc_refill | input | 1 | Request is a translation-miss refill |
| fault_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC that would have followed it |
| status_in | input | 32 | Current Status register |
| cause_in | input | 32 | Current Cause register |
| ebase_in | input | 32 | Current exception-base register |
| out_valid | output | 1 | Results below are new this cycle |
| redirect_pc | output | 32 | Handler address |
| epc_out | output | 32 | New exception PC |
| cause_out | output | 32 | New Cause value |
| status_out | output | 32 | New Status value |

## Verification
Two functions can act in the same cycle: the delay-slot backup of the saved PC, and the refill vector choice that must read the exception-level bit before this very entry sets it. The bench provokes this with a refill request whose next PC jumps away, under the boot base and with the exception level clear. It judges the cycle by four results together. The saved PC must be four below the faulting PC, the branch-delay flag must be set, the handler must sit at the bare base with offset zero, and the outgoing Status must already show the exception level set.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef logic [4:0] exc_code_t;

  // Status fields
  localparam int ST_EXL_BIT = 1;
  localparam int ST_BEV_BIT = 22;
  // Cause fields
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = 6;
  localparam int CA_IV_BIT  = 23;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_HI   = 29;
  localparam int CA_BD_BIT  = 31;

  localparam exc_code_t CODE_IRQ   = 5'd0;
  localparam exc_code_t CODE_COPUN = 5'd11;

  localparam logic [31:0] OFS_REFILL  = 32'h0000_0000;
  localparam logic [31:0] OFS_GENERAL = 32'h0000_0180;
  localparam logic [31:0] OFS_IRQ_SEP = 32'h0000_0200;
endpackage

// File: rtl/exc_slot_detect.sv
module exc_slot_detect #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] next_pc,
  output logic            in_slot,
  output logic [XLEN-1:0] epc_val
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] backup;

  always_comb begin
    seq_pc  = fault_pc + STEP;
    in_slot = (next_pc != seq_pc);
    // only the step amount is selected; the PC is always the minuend
    backup  = in_slot ? STEP : '0;
    epc_val = fault_pc - backup;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200
) (
  input  exc_code_t       code,
  input  logic            refill,
  input  logic [XLEN-1:0] status_pre,
  input  logic [XLEN-1:0] cause_pre,
  input  logic [XLEN-1:0] ebase,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base = status_pre[ST_BEV_BIT] ? XLEN'(BOOT_BASE) : ebase;
    if (code == CODE_IRQ)
      offset = cause_pre[CA_IV_BIT] ? XLEN'(OFS_IRQ_SEP) : XLEN'(OFS_GENERAL);
    else if (refill && !status_pre[ST_EXL_BIT])
      offset = XLEN'(OFS_REFILL);
    else
      offset = XLEN'(OFS_GENERAL);
    target = base + offset;
  end
endmodule

// File: rtl/exc_cause_upd.sv
module exc_cause_upd
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int COPW = 2
) (
  input  exc_code_t       code,
  input  logic [COPW-1:0] cop,
  input  logic            in_slot,
  input  logic [XLEN-1:0] cause_pre,
  input  logic [XLEN-1:0] status_pre,
  output logic [XLEN-1:0] cause_nxt,
  output logic [XLEN-1:0] status_nxt
);
  always_comb begin
    cause_nxt = cause_pre;
    cause_nxt[CA_CODE_HI:CA_CODE_LO] = code;
    cause_nxt[CA_BD_BIT] = in_slot;
    if (code == CODE_COPUN)
      cause_nxt[CA_CE_HI:CA_CE_LO] = cop;
    status_nxt = status_pre;
    status_nxt[ST_EXL_BIT] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          COPW       = 2,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_req,
  input  logic [4:0]      exc_code,
  input  logic [COPW-1:0] exc_cop,
  input  logic            exc_refill,
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] ebase_in,
  output logic            out_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc_out,
  output logic [XLEN-1:0] cause_out,
  output logic [XLEN-1:0] status_out
);
  logic            in_slot;
  logic [XLEN-1:0] epc_nxt;
  logic [XLEN-1:0] tgt_nxt;
  logic [XLEN-1:0] cause_nxt;
  logic [XLEN-1:0] status_nxt;

  exc_slot_detect #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_slot (
    .fault_pc (fault_pc),
    .next_pc  (next_pc),
    .in_slot  (in_slot),
    .epc_val  (epc_nxt)
  );

  // target uses the register values seen before this entry updates them
  exc_vector_sel #(.XLEN(XLEN), .BOOT_BASE(BOOT_BASE)) u_vec (
    .code       (exc_code),
    .refill     (exc_refill),
    .status_pre (status_in),
    .cause_pre  (cause_in),
    .ebase      (ebase_in),
    .target     (tgt_nxt)
  );

  exc_cause_upd #(.XLEN(XLEN), .COPW(COPW)) u_cause (
    .code       (exc_code),
    .cop        (exc_cop),
    .in_slot    (in_slot),
    .cause_pre  (cause_in),
    .status_pre (status_in),
    .cause_nxt  (cause_nxt),
    .status_nxt (status_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      redirect_pc <= '0;
      epc_out     <= '0;
      cause_out   <= '0;
      status_out  <= '0;
    end else begin
      out_valid <= exc_req;
      if (exc_req) begin
        redirect_pc <= tgt_nxt;
        epc_out     <= epc_nxt;
        cause_out   <= cause_nxt;
        status_out  <= status_nxt;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int COPW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_req,
  input logic [4:0]      exc_code,
  input logic            exc_refill,
  input logic [XLEN-1:0] fault_pc,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] status_in,
  input logic            out_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] epc_out,
  input logic [XLEN-1:0] cause_out,
  input logic [XLEN-1:0] status_out
);
  a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> out_valid);

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> !out_valid);

  a_r3_epc_backup: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(next_pc) != $past(fault_pc) + XLEN'(4))
      |-> epc_out == $past(fault_pc) - XLEN'(4));

  a_r4_bd_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cause_out[31] == ($past(next_pc) != $past(fault_pc) + XLEN'(4)));

  a_r8_exccode: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cause_out[6:2] == $past(exc_code));

  a_r10_exl_set: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> status_out[1]);

  a_r5_boot_general: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(status_in[22]) && $past(exc_code) != 5'd0 && !$past(exc_refill))
      |-> redirect_pc == XLEN'(32'hBFC0_0380));
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .COPW(COPW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .exc_req     (exc_req),
  .exc_code    (exc_code),
  .exc_refill  (exc_refill),
  .fault_pc    (fault_pc),
  .next_pc     (next_pc),
  .status_in   (status_in),
  .out_valid   (out_valid),
  .redirect_pc (redirect_pc),
  .epc_out     (epc_out),
  .cause_out   (cause_out),
  .status_out  (status_out)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 8;

  typedef struct packed {
    logic [4:0]  code;
    logic [1:0]  cop;
    logic        refill;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [31:0] st;
    logic [31:0] ca;
    logic [31:0] eb;
    logic [31:0] x_pc;
    logic [31:0] x_epc;
    logic [31:0] x_ca;
    logic [31:0] x_st;
  } row_t;

  // code cop ref pc npc status cause ebase | exp: redirect epc cause status
  localparam row_t TBL [NROWS] = '{
    // R6 IV set, EBASE base (R5)
    '{5'd0, 2'd0, 1'b0, 32'h100, 32'h104, 32'h0, 32'h0080_0000, 32'h8000_0000,
      32'h8000_0200, 32'h100, 32'h0080_0000, 32'h2},
    // R6 IV clear, boot base, delay slot (R2 R3 R4)
    '{5'd0, 2'd0, 1'b0, 32'h200, 32'h300, 32'h0040_0000, 32'h0, 32'h8000_0000,
      32'hBFC0_0380, 32'h1FC, 32'h8000_0000, 32'h0040_0002},
    // R7 refill, EXL clear
    '{5'd2, 2'd0, 1'b1, 32'h1000, 32'h1004, 32'h0, 32'h0080_0000, 32'h8000_0000,
      32'h8000_0000, 32'h1000, 32'h0080_0008, 32'h2},
    // R7 refill, EXL already set
    '{5'd3, 2'd0, 1'b1, 32'h2000, 32'h2004, 32'h2, 32'h0, 32'h8000_0000,
      32'h8000_0180, 32'h2000, 32'h0000_000C, 32'h2},
    // R9 coprocessor unusable overwrites CE
    '{5'd11, 2'd2, 1'b0, 32'h3000, 32'h3004, 32'h0, 32'h1000_0000, 32'h8000_0000,
      32'h8000_0180, 32'h3000, 32'h2000_002C, 32'h2},
    // R9 other code keeps CE; boot base; delay slot
    '{5'd4, 2'd3, 1'b0, 32'h4000, 32'h5000, 32'h0040_0000, 32'h1000_0000, 32'h8000_0000,
      32'hBFC0_0380, 32'h3FFC, 32'h9000_0010, 32'h0040_0002},
    // corner: refill in delay slot, boot base, EXL clear
    '{5'd2, 2'd0, 1'b1, 32'h5000, 32'h6000, 32'h0040_0000, 32'h0, 32'h8000_0000,
      32'hBFC0_0200, 32'h4FFC, 32'h8000_0008, 32'h0040_0002},
    // R4 stale BD cleared; R10 other bits pass through
    '{5'd5, 2'd0, 1'b0, 32'h6000, 32'h6004, 32'h0000_FF00, 32'h8000_0300, 32'h9000_0000,
      32'h9000_0180, 32'h6000, 32'h0000_0314, 32'h0000_FF02}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [1:0]  exc_cop = '0;
  logic        exc_refill = 1'b0;
  logic [31:0] fault_pc = '0, next_pc = '0, status_in = '0, cause_in = '0, ebase_in = '0;
  logic        out_valid;
  logic [31:0] redirect_pc, epc_out, cause_out, status_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
    .exc_cop(exc_cop), .exc_refill(exc_refill), .fault_pc(fault_pc),
    .next_pc(next_pc), .status_in(status_in), .cause_in(cause_in),
    .ebase_in(ebase_in), .out_valid(out_valid), .redirect_pc(redirect_pc),
    .epc_out(epc_out), .cause_out(cause_out), .status_out(status_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    @(negedge clk);
    exc_req = 1'b1; exc_code = r.code; exc_cop = r.cop; exc_refill = r.refill;
    fault_pc = r.pc; next_pc = r.npc; status_in = r.st; cause_in = r.ca; ebase_in = r.eb;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'b0, out_valid}, 32'h0);
    check("R11 redirect", redirect_pc, 32'h0);
    check("R11 epc", epc_out, 32'h0);
    check("R11 cause", cause_out, 32'h0);
    check("R11 status", status_out, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i]);
      check("R1 valid", {31'b0, out_valid}, 32'h1);
      check("R5/R6/R7 redirect", redirect_pc, TBL[i].x_pc);
      check("R2/R3 epc", epc_out, TBL[i].x_epc);
      check("R4/R8/R9 cause", cause_out, TBL[i].x_ca);
      check("R10 status", status_out, TBL[i].x_st);
    end

    // R1: no request -> valid low, outputs hold even when inputs change
    @(negedge clk);
    fault_pc = 32'hDEAD_0000; next_pc = 32'h1; status_in = 32'hFFFF_FFFF; exc_code = 5'd9;
    repeat (2) @(negedge clk);
    check("R1 idle valid", {31'b0, out_valid}, 32'h0);
    check("R1 hold epc", epc_out, TBL[NROWS-1].x_epc);
    check("R1 hold redirect", redirect_pc, TBL[NROWS-1].x_pc);

    // R3 wrap: delay slot at address 0
    drive('{5'd1, 2'd0, 1'b0, 32'h0, 32'h40, 32'h0, 32'h0, 32'h8000_0000,
            32'h8000_0180, 32'hFFFF_FFFC, 32'h8000_0004, 32'h2});
    check("R3 wrap epc", epc_out, 32'hFFFF_FFFC);
    check("R4 wrap bd", {31'b0, cause_out[31]}, 32'h1);

    // R1 back-to-back requests: second result follows immediately
    @(negedge clk);
    exc_req = 1'b1; exc_code = 5'd0; exc_refill = 1'b0; fault_pc = 32'h700; next_pc = 32'h704;
    status_in = 32'h0; cause_in = 32'h0080_0000; ebase_in = 32'h8000_0000;
    @(negedge clk);
    check("R1 b2b first", redirect_pc, 32'h8000_0200);
    fault_pc = 32'h800; next_pc = 32'h804; cause_in = 32'h0;
    @(negedge clk);
    exc_req = 1'b0;
    check("R6 b2b second", redirect_pc, 32'h8000_0180);
    check("R1 b2b valid", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    check("R1 b2b drop", {31'b0, out_valid}, 32'h0);

    // R11 reset clears after activity
    rst = 1'b1;
    @(negedge clk);
    check("R11 re-reset epc", epc_out, 32'h0);
    check("R11 re-reset status", status_out, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule